// File: doc/BRIEF.md
# Paged Memory Decode Unit

This unit sits between a DSP's external bus and a byte-wide memory of eight 16 KB sectors. On every bus cycle it looks at the 18-bit address and at the four active-low space strobes (I/O, byte-DMA, data and program) and produces one-hot sector selects, a select for a 256-byte control register block, an active-low chip select for an external UART, and the 17-bit byte offset that addresses the memory. All of these outputs are combinational.

The same memory is visible in two ways. In byte-DMA space it is one flat 128 KB region, and the sector number comes straight from address bits 16..14. In data space the DSP sees only a 16K-location window at addresses 0x0000–0x3FFF. An 8-bit page register then names the sector, and A13..A0 address bytes inside it. The page register belongs to the control block and sits at offset 0xE0. The DSP writes it with an I/O write and reads it back with an I/O read. Only the low byte of the 16-bit bus word is used. All decode, select and page-register logic is in scope. The memory array and the other control registers are not.

Top module: `paged_mem_decode`

## Requirements
- R1: When reset (rst_n low) releases, the page register holds 0, and an I/O read at address 0xE0 returns 0x0000 on rdata.
- R2: At most one bit of sector_sel is 1 in any cycle.
- R3: When bdm_n is the only low strobe and A17 is 0, the unit sets sector_sel bit A16..A14 and drives byte_off with A16..A0. When A17 is 1, no sector is selected.
- R4: When dmem_n is the only low strobe and the address is below 0x4000, the unit sets sector_sel bit P, where P is the page value, and drives byte_off with P*0x4000 + A13..A0. An address of 0x4000 or above selects no sector.
- R5: In data space, page values from 8 to 255 select no sector.
- R6: When iom_n is the only low strobe, ctl_sel is 1 exactly for addresses 0x000–0x0FF. No sector is selected in I/O space.
- R7: uart_cs_n is 0 exactly when iom_n is the only low strobe and the address lies in 0x200–0x207.
- R8: An I/O write (wr_n low at a rising clk edge) to address 0xE0 loads wdata[7:0] into the page register and ignores wdata[15:8]. An I/O read (rd_n low) at 0xE0 returns {8'h00, page} on rdata. In every other case rdata is 0.
- R9: While pmem_n is low, sector_sel is 0, ctl_sel is 0 and uart_cs_n is 1.
- R10: When no strobe is low, or when two or more strobes are low, sector_sel is 0, ctl_sel is 0, uart_cs_n is 1 and rdata is 0.
- R11: byte_off is 0 whenever sector_sel is 0.
- R12: A write with wr_n low leaves the page register unchanged in two cases: when it goes to any I/O address other than 0xE0, and when it happens in byte-DMA or data space at address 0xE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 18 | DSP address A17..A0 |
| iom_n | input | 1 | I/O space strobe, active low |
| bdm_n | input | 1 | Byte-DMA space strobe, active low |
| dmem_n | input | 1 | Data space strobe, active low |
| pmem_n | input | 1 | Program space strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Write data word (low byte used) |
| rdata | output | 16 | Page register readback, upper byte zero |
| sector_sel | output | 8 | One-hot sector selects |
| ctl_sel | output | 1 | Control register block select |
| uart_cs_n | output | 1 | External UART chip select, active low |
| byte_off | output | 17 | Byte offset into the 128 KB memory |

## Verification
The byte-DMA decode is tested with a strided sweep over the whole 18-bit address space. This shows whether the unit uses the right sector bits and whether it handles the 128 KB upper limit. The data-space decode is swept again for every page value from 0 to 15 and for page 255. That covers the sector chosen by the page register, the window edge at 0x4000, and the unmapped pages. The I/O range 0x000–0x3FF is swept in full, so the control-block and UART edges are exercised on both sides. All sixteen strobe patterns are applied at a set of sample addresses, which separates single-space decode from the idle, program and conflict cases. Page writes are tried with mismatched upper bytes, at neighbouring offsets, and from the wrong space.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  typedef enum logic [2:0] {
    SP_NONE = 3'd0,
    SP_IO   = 3'd1,
    SP_BYTE = 3'd2,
    SP_DATA = 3'd3,
    SP_PROG = 3'd4
  } space_e;
endpackage

// File: rtl/pmd_space_classify.sv
module pmd_space_classify
  import pmd_pkg::*;
(
  input  logic   iom_n,
  input  logic   bdm_n,
  input  logic   dmem_n,
  input  logic   pmem_n,
  output space_e space
);
  logic [3:0] act;
  logic [2:0] n_act;

  assign act = {~pmem_n, ~dmem_n, ~bdm_n, ~iom_n};

  always_comb begin
    n_act = '0;
    for (int i = 0; i < 4; i++) n_act = n_act + 3'(act[i]);
  end

  always_comb begin
    space = SP_NONE;
    if (n_act == 3'd1) begin
      unique case (1'b1)
        act[0]:  space = SP_IO;
        act[1]:  space = SP_BYTE;
        act[2]:  space = SP_DATA;
        default: space = SP_PROG;
      endcase
    end
  end
endmodule

// File: rtl/pmd_page_reg.sv
module pmd_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [PAGE_W-1:0] d,
  output logic [PAGE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/pmd_sector_decode.sv
module pmd_sector_decode
  import pmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int SECT_N  = 8,
  parameter int SECT_AW = 14,
  parameter int PAGE_W  = 8,
  localparam int SECT_W = $clog2(SECT_N),
  localparam int OFF_W  = SECT_W + SECT_AW
) (
  input  space_e            space,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic [SECT_N-1:0] sector_sel,
  output logic [OFF_W-1:0]  byte_off
);
  logic              byte_hit, data_hit, hit;
  logic [SECT_W-1:0] sect_idx;

  assign byte_hit = (space == SP_BYTE) && (addr[ADDR_W-1:OFF_W] == '0);
  assign data_hit = (space == SP_DATA) && (addr[ADDR_W-1:SECT_AW] == '0)
                    && (page < PAGE_W'(SECT_N));
  assign hit      = byte_hit || data_hit;
  assign sect_idx = byte_hit ? addr[OFF_W-1:SECT_AW] : page[SECT_W-1:0];

  for (genvar s = 0; s < SECT_N; s++) begin : g_sel
    assign sector_sel[s] = hit && (sect_idx == SECT_W'(s));
  end

  assign byte_off = hit ? {sect_idx, addr[SECT_AW-1:0]} : '0;
endmodule

// File: rtl/pmd_io_decode.sv
module pmd_io_decode
  import pmd_pkg::*;
#(
  parameter int                ADDR_W    = 18,
  parameter int                CTL_AW    = 8,
  parameter int                UART_AW   = 3,
  parameter int                PAGE_W    = 8,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTL_BASE  = '0,
  parameter logic [ADDR_W-1:0] UART_BASE = ADDR_W'('h200),
  parameter logic [CTL_AW-1:0] PAGE_OFS  = CTL_AW'('hE0)
) (
  input  space_e            space,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [PAGE_W-1:0] page,
  output logic              ctl_sel,
  output logic              uart_cs_n,
  output logic              page_ld,
  output logic [DATA_W-1:0] rdata
);
  logic is_io, at_page;

  assign is_io     = (space == SP_IO);
  assign ctl_sel   = is_io && (addr[ADDR_W-1:CTL_AW] == CTL_BASE[ADDR_W-1:CTL_AW]);
  assign uart_cs_n = !(is_io && (addr[ADDR_W-1:UART_AW] == UART_BASE[ADDR_W-1:UART_AW]));
  assign at_page   = ctl_sel && (addr[CTL_AW-1:0] == PAGE_OFS);
  assign page_ld   = at_page && !wr_n;
  assign rdata     = (at_page && !rd_n) ? {(DATA_W-PAGE_W)'(0), page} : '0;
endmodule

// File: rtl/paged_mem_decode.sv
module paged_mem_decode
  import pmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int SECT_N  = 8,
  parameter int SECT_AW = 14,
  parameter int PAGE_W  = 8,
  parameter int DATA_W  = 16,
  parameter int CTL_AW  = 8,
  parameter int UART_AW = 3,
  localparam int OFF_W  = $clog2(SECT_N) + SECT_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iom_n,
  input  logic              bdm_n,
  input  logic              dmem_n,
  input  logic              pmem_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SECT_N-1:0] sector_sel,
  output logic              ctl_sel,
  output logic              uart_cs_n,
  output logic [OFF_W-1:0]  byte_off
);
  space_e            space;
  logic [PAGE_W-1:0] page;
  logic              page_ld;

  pmd_space_classify u_cls (
    .iom_n (iom_n), .bdm_n (bdm_n), .dmem_n (dmem_n), .pmem_n (pmem_n),
    .space (space)
  );

  pmd_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk (clk), .rst_n (rst_n), .ld (page_ld),
    .d (wdata[PAGE_W-1:0]), .q (page)
  );

  pmd_sector_decode #(
    .ADDR_W (ADDR_W), .SECT_N (SECT_N), .SECT_AW (SECT_AW), .PAGE_W (PAGE_W)
  ) u_sect (
    .space (space), .addr (addr), .page (page),
    .sector_sel (sector_sel), .byte_off (byte_off)
  );

  pmd_io_decode #(
    .ADDR_W (ADDR_W), .CTL_AW (CTL_AW), .UART_AW (UART_AW),
    .PAGE_W (PAGE_W), .DATA_W (DATA_W)
  ) u_io (
    .space (space), .addr (addr), .rd_n (rd_n), .wr_n (wr_n), .page (page),
    .ctl_sel (ctl_sel), .uart_cs_n (uart_cs_n), .page_ld (page_ld), .rdata (rdata)
  );
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
  parameter int ADDR_W  = 18,
  parameter int SECT_N  = 8,
  parameter int SECT_AW = 14,
  parameter int DATA_W  = 16,
  parameter int UART_AW = 3,
  localparam int OFF_W  = $clog2(SECT_N) + SECT_AW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              iom_n,
  input logic              bdm_n,
  input logic              dmem_n,
  input logic              pmem_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [SECT_N-1:0] sector_sel,
  input logic              ctl_sel,
  input logic              uart_cs_n,
  input logic [OFF_W-1:0]  byte_off
);
  logic [3:0] stb_n;
  logic       quiet;
  assign stb_n = {pmem_n, dmem_n, bdm_n, iom_n};
  assign quiet = (sector_sel == '0) && !ctl_sel && uart_cs_n;

  AST_SECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sector_sel)); // R2
  AST_BYTE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_n == 4'b1101 && addr[ADDR_W-1:OFF_W] == '0)
      |-> (sector_sel == (SECT_N'(1) << addr[OFF_W-1:SECT_AW]))); // R3
  AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_n == 4'b1011 && addr[ADDR_W-1:SECT_AW] != '0) |-> (sector_sel == '0)); // R4
  AST_IO_NO_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !iom_n |-> (sector_sel == '0)); // R6
  AST_UART_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_cs_n |-> (stb_n == 4'b1110 && addr[ADDR_W-1:UART_AW] == (ADDR_W-UART_AW)'('h40))); // R7
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pmem_n |-> quiet); // R9
  AST_MULTI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(stb_n) != 3) |-> (quiet && rdata == '0)); // R10
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_sel == '0) |-> (byte_off == '0)); // R11
endmodule

bind paged_mem_decode pmd_checker #(
  .ADDR_W (ADDR_W), .SECT_N (SECT_N), .SECT_AW (SECT_AW),
  .DATA_W (DATA_W), .UART_AW (UART_AW)
) chk_i (.*);

// File: tb/paged_mem_decode_tb_top.sv
`timescale 1ns/1ps
module paged_mem_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        iom_n = 1'b1, bdm_n = 1'b1, dmem_n = 1'b1, pmem_n = 1'b1;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  sector_sel;
  logic        ctl_sel, uart_cs_n;
  logic [16:0] byte_off;

  int checks = 0;
  int errors = 0;
  logic [7:0] page_m = 8'h00;

  always #2.5 clk = ~clk;

  paged_mem_decode dut_i (
    .clk (clk), .rst_n (rst_n), .addr (addr),
    .iom_n (iom_n), .bdm_n (bdm_n), .dmem_n (dmem_n), .pmem_n (pmem_n),
    .rd_n (rd_n), .wr_n (wr_n), .wdata (wdata), .rdata (rdata),
    .sector_sel (sector_sel), .ctl_sel (ctl_sel), .uart_cs_n (uart_cs_n),
    .byte_off (byte_off)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h addr=%h stb=%b page=%h",
               req, act, exp, addr, {pmem_n, dmem_n, bdm_n, iom_n}, page_m);
    end
  endtask

  // stb = {pmem_n, dmem_n, bdm_n, iom_n}
  task automatic apply_chk(input logic [3:0] stb, input logic [17:0] a, input logic rdn, input string req);
    int lows;
    logic [7:0]  e_sel;
    logic [16:0] e_off;
    logic        e_ctl, e_ucs;
    logic [15:0] e_rd;
    {pmem_n, dmem_n, bdm_n, iom_n} = stb;
    addr = a; rd_n = rdn; wr_n = 1'b1;
    #1;
    lows = 0;
    for (int i = 0; i < 4; i++) if (!stb[i]) lows++;
    e_sel = '0; e_off = '0; e_ctl = 1'b0; e_ucs = 1'b1; e_rd = '0;
    if (lows == 1 && !stb[1] && a < 18'h20000) begin
      e_sel = 8'(1 << (a / 18'h4000));
      e_off = 17'(a);
    end
    if (lows == 1 && !stb[2] && a < 18'h4000 && page_m < 8) begin
      e_sel = 8'(1 << page_m);
      e_off = 17'(page_m * 32'h4000 + a);
    end
    if (lows == 1 && !stb[0]) begin
      e_ctl = (a < 18'h100);
      e_ucs = !(a >= 18'h200 && a < 18'h208);
      if (a == 18'h0E0 && !rdn) e_rd = {8'h00, page_m};
    end
    chk(sector_sel == e_sel, {req, " sector_sel R2"}, 32'(sector_sel), 32'(e_sel));
    chk(byte_off == e_off, {req, " byte_off R11"}, 32'(byte_off), 32'(e_off));
    chk(ctl_sel == e_ctl, {req, " ctl_sel R6"}, 32'(ctl_sel), 32'(e_ctl));
    chk(uart_cs_n == e_ucs, {req, " uart_cs_n R7"}, 32'(uart_cs_n), 32'(e_ucs));
    chk(rdata == e_rd, {req, " rdata R8"}, 32'(rdata), 32'(e_rd));
  endtask

  task automatic bus_write(input logic [3:0] stb, input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    {pmem_n, dmem_n, bdm_n, iom_n} = stb;
    addr = a; wdata = d; wr_n = 1'b0; rd_n = 1'b1;
    @(posedge clk);
    #1;
    wr_n = 1'b1;
    {pmem_n, dmem_n, bdm_n, iom_n} = 4'b1111;
    @(negedge clk);
  endtask

  task automatic read_page(input string req);
    apply_chk(4'b1110, 18'h0E0, 1'b0, req);
    rd_n = 1'b1;
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state: R1, R10
    #12;
    chk(sector_sel == 8'h00, "R1 reset sector_sel", 32'(sector_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_page("R1 reset page");
    apply_chk(4'b1111, 18'h00000, 1'b0, "R10 idle");

    // Byte-DMA flat map sweep: R3
    for (int a = 0; a < 32'h40000; a += 32'hFF) apply_chk(4'b1101, 18'(a), 1'b1, "R3 byte");
    apply_chk(4'b1101, 18'h1FFFF, 1'b1, "R3 byte top");
    apply_chk(4'b1101, 18'h20000, 1'b1, "R3 byte beyond");
    apply_chk(4'b1101, 18'h03FFF, 1'b1, "R3 byte edge");
    apply_chk(4'b1101, 18'h04000, 1'b1, "R3 byte edge");

    // Data window sweep for pages 0..15 and 255: R4, R5, R8
    for (int p = 0; p < 17; p++) begin
      logic [7:0] pv;
      pv = (p == 16) ? 8'hFF : 8'(p);
      bus_write(4'b1110, 18'h0E0, {~pv, pv});
      page_m = pv;
      read_page("R8 page readback");
      for (int a = 0; a < 32'h40000; a += 32'h1FF)
        apply_chk(4'b1011, 18'(a), 1'b1, (pv < 8) ? "R4 data" : "R5 data");
      apply_chk(4'b1011, 18'h03FFF, 1'b1, "R4 window edge");
      apply_chk(4'b1011, 18'h04000, 1'b1, "R4 window edge");
      apply_chk(4'b1011, 18'h02000, 1'b1, "R4 A13 half");
    end

    // I/O space sweep: R6, R7, R8
    bus_write(4'b1110, 18'h0E0, 16'hFF05);
    page_m = 8'h05;
    for (int a = 0; a < 32'h400; a++) begin
      apply_chk(4'b1110, 18'(a), 1'b1, "R6 io");
      if (a >= 32'hDE && a <= 32'hE2) apply_chk(4'b1110, 18'(a), 1'b0, "R8 io read");
    end
    apply_chk(4'b1110, 18'h10200, 1'b1, "R7 io high alias");

    // Strobe patterns incl. program and conflicts: R9, R10
    for (int s = 0; s < 16; s++)
      for (int a = 0; a < 32'h40000; a += 32'h2041) begin
        apply_chk(4'(s), 18'(a), 1'b0, (s[3] == 1'b0) ? "R9 prog" : "R10 strobes");
      end
    apply_chk(4'b0111, 18'h0E0, 1'b0, "R9 prog read");
    apply_chk(4'b1100, 18'h0E0, 1'b0, "R10 double");
    apply_chk(4'b1111, 18'h00204, 1'b0, "R10 none");

    // Writes that must not touch the page register: R12
    bus_write(4'b1110, 18'h0E1, 16'h0003);
    read_page("R12 io neighbour");
    bus_write(4'b1110, 18'h0DF, 16'h0003);
    read_page("R12 io neighbour");
    bus_write(4'b1101, 18'h0E0, 16'h0003);
    read_page("R12 byte space");
    bus_write(4'b1011, 18'h0E0, 16'h0003);
    read_page("R12 data space");
    bus_write(4'b1010, 18'h0E0, 16'h0003);
    read_page("R12 conflict");
    apply_chk(4'b1011, 18'h01234, 1'b1, "R12 data uses kept page");

    // Reset clears page again: R1
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    rst_n = 1'b1;
    page_m = 8'h00;
    @(negedge clk);
    read_page("R1 re-reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule